// File: doc/BRIEF.md
# PHY Management Serial Command Controller

This block lets a host run single management transactions on the two-wire serial bus that configures an Ethernet PHY. The host sets a clock divisor and an enable bit, loads a 16-bit value for writes, and then writes a command word. The command word carries the PHY address, the register address, the operation and a go bit. The controller shifts out a complete 64-bit frame on the data line, timed by a management clock that it derives from the system clock. On reads it releases the line and collects the 16 bits that the PHY returns.

The host sees four 32-bit registers, selected by a 2-bit offset. Writes take effect on the clock edge where `reg_wr` is high. Reads come straight from `reg_rdata` as a combinational function of `reg_addr`. A ready bit in the setup/status word tells the host when the controller can take the next command. A bad configuration, or a command that is refused, is reported through two read-only status bits.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The setup register (offset 0) keeps only bits 6:0 of a write: bits 5:0 are the clock divisor and bit 6 is the enable. On a read, offset 0 returns these seven bits, with ready in bit 7, the configuration error in bit 8 and the reject flag in bit 9. All higher bits read as zero.
- R2: When enable is set and the divisor is zero, status bit 8 reads 1. A command issued in that state starts no transaction: MDC stays low.
- R3: During a transaction, MDC has a period of 2*(divisor+1) system clocks. While no transaction is running, MDC is held low.
- R4: The command word (offset 1) is decoded as follows: PHY address in bits 28:24, register address in bits 20:16, op in bits 15:14, go in bit 11. With go set, op 1 sends a write frame. Its 64 bits, counted on MDC rising edges, are: 32 ones, 01, 01, PHY address, register address, 10, and then the write-data register (offset 2, bits 15:0), MSB first. MDIO is driven for the whole frame.
- R5: With go set, op 2 sends 32 ones, 01, 10, the PHY address and the register address. The controller then releases MDIO for two turnaround bits and 16 data bits. It samples the data on MDC rising edges, MSB first, and places it in the read-data register (offset 3, bits 15:0).
- R6: A command with go set and op 0 or op 3 starts no transaction and sets the reject flag (status bit 9). The next accepted command clears the flag.
- R7: A command write with bit 11 clear starts nothing and leaves the status unchanged.
- R8: Ready (status bit 7) reads 0 from the clock after an accepted command until the frame ends. It reads 1 at all other times, including after reset.
- R9: A command written while a transaction is running is ignored. The frame in flight is unchanged, and no second frame follows.
- R10: MDIO output enable is low whenever no transaction is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 setup/status, 1 command, 2 write data, 3 read data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Serial data sampled from the line |

## Verification
Register effects appear one clock after the write edge. Status is combinational, so ready reads low at the very next falling clock edge after an accepted command. The bench checks it there. Frame bits count as due on MDC rising edges, where a PHY would sample them, so the bench model captures `mdio_o` and `mdio_oe` on each MDC rise. It drives read data on MDC falling edges, one full half-period before the controller samples. Results of a whole frame (its bit pattern, its rise count, the MDC period and the read-data register) are checked only after ready has returned high. Cases that start nothing are checked after a fixed idle window of 40 or more clocks, by confirming that no MDC rise occurred.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int MDIO_DIV_W     = 6;
    localparam int MDIO_ADDR_W    = 5;
    localparam int MDIO_DATA_W    = 16;
    localparam int MDIO_PRE_LEN   = 32;
    localparam int MDIO_FRAME_LEN = MDIO_PRE_LEN + 2 + 2 + 2*MDIO_ADDR_W + 2 + MDIO_DATA_W;
    localparam int MDIO_SETUP_W   = MDIO_DIV_W + 1;

    localparam int CMD_PHY_LSB = 24;
    localparam int CMD_REG_LSB = 16;
    localparam int CMD_OP_LSB  = 14;
    localparam int CMD_GO_BIT  = 11;

    localparam logic [1:0] OFS_SETUP = 2'd0;
    localparam logic [1:0] OFS_CMD   = 2'd1;
    localparam logic [1:0] OFS_WDATA = 2'd2;
    localparam logic [1:0] OFS_RDATA = 2'd3;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_BAD  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e                 op;
        logic [MDIO_ADDR_W-1:0]   phy;
        logic [MDIO_ADDR_W-1:0]   regad;
        logic                     go;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        c.op    = mdio_op_e'(w[CMD_OP_LSB +: 2]);
        c.phy   = w[CMD_PHY_LSB +: MDIO_ADDR_W];
        c.regad = w[CMD_REG_LSB +: MDIO_ADDR_W];
        c.go    = w[CMD_GO_BIT];
        return c;
    endfunction

    function automatic logic op_is_valid(input mdio_op_e op);
        return (op == OP_WR) || (op == OP_RD);
    endfunction

    // Whole frame, first bit on the wire in the MSB.
    function automatic logic [MDIO_FRAME_LEN-1:0] build_frame(
        input mdio_cmd_t c, input logic [MDIO_DATA_W-1:0] data);
        logic [1:0]             ta;
        logic [MDIO_DATA_W-1:0] payload;
        ta      = (c.op == OP_WR) ? 2'b10 : 2'b11;
        payload = (c.op == OP_WR) ? data : '1;
        return {{MDIO_PRE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int DIV_W = MDIO_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    assign tick = run && (cnt_q == div);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int FRAME_LEN = MDIO_FRAME_LEN,
    parameter int DATA_W    = MDIO_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mdio_op_e             start_op,
    input  logic [FRAME_LEN-1:0] start_frame,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 busy,
    output mdio_op_e             cur_op,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int IDX_W   = $clog2(FRAME_LEN);
    localparam int RLS_IDX = FRAME_LEN - DATA_W - 2;
    localparam int DAT_IDX = FRAME_LEN - DATA_W;
    localparam int LAST    = FRAME_LEN - 1;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    eng_state_e           state_q;
    logic [FRAME_LEN-1:0] shreg_q;
    logic [IDX_W-1:0]     idx_q;
    mdio_op_e             op_q;
    logic [DATA_W-1:0]    rd_q;
    logic                 released;

    assign busy     = (state_q == ENG_RUN);
    assign cur_op   = op_q;
    assign released = (op_q == OP_RD) && (idx_q >= IDX_W'(RLS_IDX));
    assign mdio_oe  = busy && !released;
    assign mdio_o   = busy ? shreg_q[FRAME_LEN-1] : 1'b1;
    assign done     = busy && fall && (idx_q == IDX_W'(LAST));
    assign rd_data  = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            op_q    <= OP_NONE;
            rd_q    <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_q <= ENG_RUN;
                        shreg_q <= start_frame;
                        idx_q   <= '0;
                        op_q    <= start_op;
                    end
                end
                ENG_RUN: begin
                    if (rise && (op_q == OP_RD) && (idx_q >= IDX_W'(DAT_IDX))) begin
                        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
                    end
                    if (fall) begin
                        if (idx_q == IDX_W'(LAST)) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [MDIO_SETUP_W-1:0]   setup_q;
    logic [31:0]               cmd_q;
    logic [MDIO_DATA_W-1:0]    wdata_q;
    logic [MDIO_DATA_W-1:0]    rdata_q;
    logic                      reject_q;

    logic [MDIO_DIV_W-1:0]     div;
    logic                      en;
    logic                      cfg_err;
    mdio_cmd_t                 cmd;
    logic                      issue;
    logic                      accept;
    logic                      busy;
    logic                      rise;
    logic                      fall;
    logic                      done;
    mdio_op_e                  cur_op;
    logic [MDIO_DATA_W-1:0]    eng_rd;
    logic [MDIO_FRAME_LEN-1:0] frame;

    assign div     = setup_q[MDIO_DIV_W-1:0];
    assign en      = setup_q[MDIO_DIV_W];
    assign cfg_err = en && (div == '0);
    assign cmd     = decode_cmd(reg_wdata);
    assign issue   = reg_wr && (reg_addr == OFS_CMD) && cmd.go && !busy;
    assign accept  = issue && en && !cfg_err && op_is_valid(cmd.op);
    assign frame   = build_frame(cmd, wdata_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q  <= '0;
            cmd_q    <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            reject_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_SETUP: setup_q <= reg_wdata[MDIO_SETUP_W-1:0];
                    OFS_CMD:   if (!busy) cmd_q <= reg_wdata;
                    OFS_WDATA: wdata_q <= reg_wdata[MDIO_DATA_W-1:0];
                    default:   ;
                endcase
            end
            if (accept) begin
                reject_q <= 1'b0;
            end else if (issue) begin
                reject_q <= 1'b1;
            end
            if (done && (cur_op == OP_RD)) begin
                rdata_q <= eng_rd;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SETUP: reg_rdata = {22'd0, reject_q, cfg_err, ~busy, setup_q};
            OFS_CMD:   reg_rdata = cmd_q;
            OFS_WDATA: reg_rdata = {{(32-MDIO_DATA_W){1'b0}}, wdata_q};
            default:   reg_rdata = {{(32-MDIO_DATA_W){1'b0}}, rdata_q};
        endcase
    end

    mdio_clkgen #(.DIV_W(MDIO_DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_eng #(.FRAME_LEN(MDIO_FRAME_LEN), .DATA_W(MDIO_DATA_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_op    (cmd.op),
        .start_frame (frame),
        .rise        (rise),
        .fall        (fall),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .cur_op      (cur_op),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (done),
        .rd_data     (eng_rd)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     mdc,
    input logic     mdio_oe,
    input logic     busy,
    input logic     cfg_err,
    input mdio_op_e cur_op
);
    // R10: line released when idle
    a_r10_oe_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    // R3: clock parked low when idle
    a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R3: clock only moves while a frame runs
    a_r3_mdc_moves_busy: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdc) |-> $past(busy));

    // R2: bad configuration never lets a frame start
    a_r2_cfg_err_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_err) |=> !busy);

    // R6: only write or read frames ever start
    a_r6_valid_op_only: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((cur_op == OP_WR) || (cur_op == OP_RD)));

    // R9: operation in flight is never replaced
    a_r9_op_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_op));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .cfg_err (cfg_err),
    .cur_op  (cur_op)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int period = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    logic [15:0] rd_val = '0;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge clk) cyc = cyc + 1;

    // PHY side model
    always @(posedge mdc) begin
        cap       = {cap[62:0], mdio_o};
        oe_cap    = {oe_cap[62:0], mdio_oe};
        period    = cyc - last_rise;
        last_rise = cyc;
        rises     = rises + 1;
    end

    always @(negedge mdc) begin
        if (rises >= 48 && rises <= 63) mdio_i = rd_val[63 - rises];
        else mdio_i = 1'b1;
    end

    // go, op[1:0], phy[4:0], reg[4:0], data[15:0]
    localparam logic [28:0] VECS [8] = '{
        {1'b1, 2'b01, 5'd7,  5'd0,  16'h3100},
        {1'b1, 2'b10, 5'd7,  5'd2,  16'h0141},
        {1'b1, 2'b01, 5'd31, 5'd31, 16'hA5C3},
        {1'b1, 2'b10, 5'd0,  5'd4,  16'h8001},
        {1'b1, 2'b00, 5'd3,  5'd3,  16'h1111},
        {1'b1, 2'b11, 5'd3,  5'd3,  16'h2222},
        {1'b0, 2'b01, 5'd5,  5'd6,  16'h3333},
        {1'b1, 2'b10, 5'd1,  5'd17, 16'hFFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_phy();
        rises = 0; cap = '0; oe_cap = '0;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd(2'd0, s);
            if (s[7]) break;
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic go, input logic [1:0] op,
                                              input logic [4:0] phy, input logic [4:0] ra);
        return (32'(phy) << 24) | (32'(ra) << 16) | (32'(op) << 14) | (32'(go) << 11);
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [63:0] exp_f;
        logic [63:0] exp_oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        rd(2'd0, s);
        chk("R8 reset status", 64'(s), 64'h80);
        chk("R10 reset oe", 64'(mdio_oe), 64'd0);
        chk("R3 reset mdc", 64'(mdc), 64'd0);
        rd(2'd3, s);
        chk("R5 reset rdata", 64'(s), 64'd0);

        // R1 masking
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, s);
        chk("R1 setup mask", 64'(s), 64'h0FF);

        // R2 enabled with zero divisor
        wr(2'd0, 32'h0000_0040);
        rd(2'd0, s);
        chk("R2 cfg error flag", 64'(s), 64'h1C0);
        clear_phy();
        wr(2'd2, 32'h0000_BEEF);
        wr(2'd1, cmd_word(1'b1, 2'b01, 5'd2, 5'd2));
        repeat (50) @(negedge clk);
        chk("R2 no frame", 64'(rises), 64'd0);
        rd(2'd0, s);
        chk("R2 refused status", 64'(s), 64'h3C0);

        // R3 divisor 2: period 6 clocks
        wr(2'd0, 32'h0000_0042);
        clear_phy();
        wr(2'd1, cmd_word(1'b1, 2'b01, 5'd2, 5'd2));
        rd(2'd0, s);
        chk("R8 ready low after accept", 64'(s[7]), 64'd0);
        wait_ready();
        chk("R3 period div2", 64'(period), 64'd6);
        chk("R3 rises div2", 64'(rises), 64'd64);
        chk("R3 mdc low after", 64'(mdc), 64'd0);
        chk("R10 oe low after", 64'(mdio_oe), 64'd0);

        // Vector table at divisor 1
        wr(2'd0, 32'h0000_0041);
        for (int v = 0; v < 8; v++) begin
            logic        go;
            logic [1:0]  op;
            logic [4:0]  phy;
            logic [4:0]  ra;
            logic [15:0] dat;
            logic [31:0] prev;
            {go, op, phy, ra, dat} = VECS[v];
            rd(2'd0, prev);
            clear_phy();
            rd_val = dat;
            wr(2'd2, 32'(dat));
            wr(2'd1, cmd_word(go, op, phy, ra));
            if (go && (op == 2'b01 || op == 2'b10)) begin
                rd(2'd0, s);
                chk($sformatf("R8 ready low v%0d", v), 64'(s[7]), 64'd0);
                wait_ready();
                chk($sformatf("R4/R5 rise count v%0d", v), 64'(rises), 64'd64);
                if (op == 2'b01) begin
                    exp_f  = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, dat};
                    exp_oe = '1;
                    chk($sformatf("R4 write frame v%0d", v), cap, exp_f);
                    chk($sformatf("R4 write oe v%0d", v), oe_cap, exp_oe);
                end else begin
                    exp_f  = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 18'd0};
                    exp_oe = {46'h3FFF_FFFF_FFFF, 18'd0};
                    chk($sformatf("R5 read header v%0d", v), cap & exp_oe, exp_f);
                    chk($sformatf("R5 read oe v%0d", v), oe_cap, exp_oe);
                    rd(2'd3, s);
                    chk($sformatf("R5 read data v%0d", v), 64'(s), 64'(dat));
                end
                rd(2'd0, s);
                chk($sformatf("R6 reject clear v%0d", v), 64'(s[9]), 64'd0);
            end else begin
                repeat (40) @(negedge clk);
                chk($sformatf("R6/R7 no frame v%0d", v), 64'(rises), 64'd0);
                rd(2'd0, s);
                if (go) chk($sformatf("R6 reject set v%0d", v), 64'(s), 64'h2C1);
                else    chk($sformatf("R7 status kept v%0d", v), 64'(s), 64'(prev));
            end
        end

        // R9 command during a frame
        clear_phy();
        wr(2'd2, 32'h0000_1234);
        wr(2'd1, cmd_word(1'b1, 2'b01, 5'd3, 5'd5));
        repeat (20) @(negedge clk);
        wr(2'd1, cmd_word(1'b1, 2'b10, 5'd9, 5'd9));
        wait_ready();
        exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'h1234};
        chk("R9 frame unchanged", cap, exp_f);
        repeat (100) @(negedge clk);
        chk("R9 single frame", 64'(rises), 64'd64);
        rd(2'd0, s);
        chk("R9 status idle", 64'(s), 64'h0C1);

        summary();
        $finish;
    end
endmodule